// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of sixteen general-purpose I/O lines behind a 16-bit register bus. Each line is set to input or output. An output line drives the value held in the output register. Input lines pass through a two-flop synchronizer, and their current values can be read back.

Each input line can raise an interrupt on an edge. A per-line polarity bit chooses a rising or a falling edge. A line records an interrupt only when it is an input, its mask bit is clear, and the functional clock enable is high. Reading the status register returns its value and then clears only the bits whose mask bit is clear. The single interrupt output is high while any status bit is set.

An event mode watches one chosen pin. When that pin changes while it qualifies, the whole 16-bit input word is copied into a latch register. A debounce-time field is stored for software but does not filter the inputs.

The register bus has no back-pressure. A request is taken in the cycle `reg_req` is high. Read data appears on `reg_rdata` one clock later and holds until the next read.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the direction register reads 0xFFFF (all lines are inputs). The output, event-mode, polarity, mask, debounce, latch and status registers read 0. `irq` is 0 and `pin_oe` is 0.
- R2: A direction bit of 0 makes its line an output, with `pin_oe` bit 1 and `pin_out` equal to the output-register bit. A direction bit of 1 forces both to 0. Both follow a direction or output write from the clock edge that takes the write. The output register (offset 0x04) reads back the full written value whatever the direction.
- R3: A status bit (offset 0x24) is set by a 0-to-1 transition of its synchronized input when its polarity bit (offset 0x1C) is 1, and by a 1-to-0 transition when that bit is 0. A transition of the other kind, or no change, sets nothing. `irq` is the OR of all status bits.
- R4: A transition sets no status bit when any one of these holds: the line's direction bit (offset 0x08) is 0, its mask bit (offset 0x2C) is 1, or `func_clk_en` is 0.
- R5: A status read returns the value held before the read. After the read, bits whose mask bit is 0 are cleared and bits whose mask bit is 1 are kept. A bit set by a new edge in the same cycle is kept.
- R6: The event-mode register (offset 0x18) uses bit 0 as enable and bits 4:1 as the pin number. While it is enabled, a change in either direction of the chosen pin, when that pin is an unmasked input and `func_clk_en` is 1, copies the synchronized 16-bit input word into the latch (offset 0x34). Changes on other pins, or any change while the register is disabled, leave the latch unchanged.
- R7: The event-mode register keeps only the low 5 written bits, and the debounce register (offset 0x30) keeps only the low 9. The polarity and mask registers keep all 16 bits.
- R8: Writes to the read-only offsets 0x00, 0x24 and 0x34, and to unmapped offsets, change nothing. Reads of unmapped offsets return 0.
- R9: The input register (offset 0x00) shows a pin change two clocks after it is sampled. A read captured at the second clock edge still returns the old value. A read one cycle later returns the new value.
- R10: `reg_rdata` holds the last read result, unaffected by later writes, until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_clk_en | input | 1 | Functional clock enable; gates interrupt and event capture |
| reg_req | input | 1 | Register access request, one per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after a read request |
| pin_in | input | 16 | Asynchronous line inputs |
| pin_out | output | 16 | Driven line values (0 on input lines) |
| pin_oe | output | 16 | Output enable per line |
| irq | output | 1 | Level interrupt, OR of status bits |

## Verification
The edge detector is driven from a table. Each entry names one line, a polarity, a start and end level, and the gating conditions. Rising-only and falling-only entries on the same line separate a correct polarity decode from one that fires on any change. Entries on lines 0, 7, 12 and 15 catch a wrong bit index. Separate entries gate the line with the mask, with the output direction and with the clock enable, which isolates each qualifier.

Directed sequences cover the rest:
- Clear-on-read with a mask bit set part way through, which shows that masked bits are kept.
- Event capture on the chosen pin, on another pin, and with the enable off.
- Truncated writes to the event-mode and debounce registers.
- Writes to read-only offsets.
- The exact cycle at which a pin change first appears in the input register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 6;

  typedef enum logic [REG_AW-1:0] {
    OFS_IN    = 6'h00,
    OFS_OUT   = 6'h04,
    OFS_DIR   = 6'h08,
    OFS_EVT   = 6'h18,
    OFS_POL   = 6'h1C,
    OFS_STAT  = 6'h24,
    OFS_MASK  = 6'h2C,
    OFS_DEB   = 6'h30,
    OFS_LATCH = 6'h34
  } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEB_W = 9,
  parameter int unsigned EVT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     in_val,
  input  logic [DW-1:0]     status,
  input  logic [DW-1:0]     latch,
  output logic [DW-1:0]     out_q,
  output logic [DW-1:0]     dir_q,
  output logic [DW-1:0]     pol_q,
  output logic [DW-1:0]     mask_q,
  output logic [EVT_W-1:0]  evt_q,
  output logic [DW-1:0]     rdata,
  output logic              stat_rd
);
  logic [DEB_W-1:0] deb_q;
  logic [DW-1:0]    rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      pol_q  <= '0;
      mask_q <= '0;
      evt_q  <= '0;
      deb_q  <= '0;
    end else if (req && we) begin
      case (addr)
        OFS_OUT:  out_q  <= wdata;
        OFS_DIR:  dir_q  <= wdata;
        OFS_POL:  pol_q  <= wdata;
        OFS_MASK: mask_q <= wdata;
        OFS_EVT:  evt_q  <= wdata[EVT_W-1:0];
        OFS_DEB:  deb_q  <= wdata[DEB_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_IN:    rd_mux = in_val;
      OFS_OUT:   rd_mux = out_q;
      OFS_DIR:   rd_mux = dir_q;
      OFS_POL:   rd_mux = pol_q;
      OFS_MASK:  rd_mux = mask_q;
      OFS_STAT:  rd_mux = status;
      OFS_LATCH: rd_mux = latch;
      OFS_EVT:   rd_mux = {{(DW-EVT_W){1'b0}}, evt_q};
      OFS_DEB:   rd_mux = {{(DW-DEB_W){1'b0}}, deb_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (req && !we) rdata <= rd_mux;
  end

  assign stat_rd = req && !we && (addr == OFS_STAT);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned DW    = 16,
  parameter int unsigned EVT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [DW-1:0]    cur,
  input  logic [DW-1:0]    prev,
  input  logic [DW-1:0]    dir,
  input  logic [DW-1:0]    mask,
  input  logic [DW-1:0]    pol,
  input  logic [EVT_W-1:0] evt,
  input  logic             stat_rd,
  output logic [DW-1:0]    status,
  output logic [DW-1:0]    latch
);
  localparam int unsigned SEL_W = EVT_W - 1;

  logic [DW-1:0]    qual, rise, fall, hit, clr;
  logic [SEL_W-1:0] sel;
  logic             ev_fire;

  assign qual = dir & ~mask & {DW{clk_en}};
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
  assign hit  = qual & ((pol & rise) | (~pol & fall));
  assign clr  = stat_rd ? ~mask : '0;

  assign sel     = evt[EVT_W-1:1];
  assign ev_fire = evt[0] && qual[sel] && (cur[sel] != prev[sel]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      latch  <= '0;
    end else begin
      status <= (status & ~clr) | hit;
      if (ev_fire) latch <= cur;
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEB_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              func_clk_en,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic              irq
);
  localparam int unsigned SEL_W = $clog2(DATA_W);
  localparam int unsigned EVT_W = SEL_W + 1;

  logic [DATA_W-1:0] in_cur, in_prev;
  logic [DATA_W-1:0] out_q, dir_q, pol_q, mask_q, status_q, latch_q;
  logic [EVT_W-1:0]  evt_q;
  logic              stat_rd;

  gpio_sync #(.W(DATA_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (pin_in),
    .q      (in_cur),
    .q_prev (in_prev)
  );

  gpio_regfile #(.DW(DATA_W), .DEB_W(DEB_W), .EVT_W(EVT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (reg_req),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .in_val  (in_cur),
    .status  (status_q),
    .latch   (latch_q),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .pol_q   (pol_q),
    .mask_q  (mask_q),
    .evt_q   (evt_q),
    .rdata   (reg_rdata),
    .stat_rd (stat_rd)
  );

  gpio_edge_irq #(.DW(DATA_W), .EVT_W(EVT_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (func_clk_en),
    .cur     (in_cur),
    .prev    (in_prev),
    .dir     (dir_q),
    .mask    (mask_q),
    .pol     (pol_q),
    .evt     (evt_q),
    .stat_rd (stat_rd),
    .status  (status_q),
    .latch   (latch_q)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q & ~dir_q;
  assign irq     = |status_q;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              func_clk_en,
  input logic              reg_req,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic [DW-1:0]     pin_out,
  input logic [DW-1:0]     pin_oe,
  input logic [DW-1:0]     status,
  input logic [DW-1:0]     mask
);
  logic mapped, rd_stat, rd_any;

  always_comb begin
    case (reg_addr)
      OFS_IN, OFS_OUT, OFS_DIR, OFS_EVT, OFS_POL,
      OFS_STAT, OFS_MASK, OFS_DEB, OFS_LATCH: mapped = 1'b1;
      default: mapped = 1'b0;
    endcase
  end

  assign rd_any  = reg_req && !reg_we;
  assign rd_stat = rd_any && (reg_addr == OFS_STAT);

  // R2: only enabled lines drive a one
  always_comb begin
    if (rst_n) p_drive_gated_r2: assert ((pin_out & ~pin_oe) == '0);
  end

  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == OFS_DIR) |=> (pin_oe == ~$past(reg_wdata)));

  p_no_set_clk_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !func_clk_en |=> ((status & ~$past(status)) == '0));

  p_status_rdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (reg_rdata == $past(status)));

  p_masked_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> ((status & $past(mask)) == ($past(status) & $past(mask))));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && !mapped) |=> (reg_rdata == '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.DW(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .func_clk_en (func_clk_en),
  .reg_req     (reg_req),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .status      (status_q),
  .mask        (mask_q)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
  localparam int CLK_P = 10;
  localparam int NV = 10;

  // Fields: [10:7] line, [6] polarity, [5] masked, [4] line is output,
  // [3] clock enable off, [2] start level, [1] end level, [0] expected status bit
  localparam logic [10:0] VECS [NV] = '{
    {4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd7,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd4,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        func_clk_en = 1'b1;
  logic        reg_req = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata, pin_out, pin_oe;
  logic [15:0] pin_in = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] rv;

  always #(CLK_P/2) clk = ~clk;

  gpio_edge_bank u_dut (
    .clk(clk), .rst_n(rst_n), .func_clk_en(func_clk_en),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_req = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h08, rv); chk("R1 dir", rv, 16'hFFFF);
    rd(6'h04, rv); chk("R1 out", rv, 16'h0000);
    rd(6'h24, rv); chk("R1 status", rv, 16'h0000);
    rd(6'h18, rv); chk("R1 evt", rv, 16'h0000);
    rd(6'h34, rv); chk("R1 latch", rv, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    chk("R1 oe", pin_oe, 16'h0000);

    // Table-driven edge detection (R3, R4)
    for (int i = 0; i < NV; i++) begin
      logic [3:0] ln;
      string tag;
      ln  = VECS[i][10:7];
      tag = (VECS[i][5] || VECS[i][4] || VECS[i][3]) ? "R4" : "R3";
      func_clk_en = 1'b1;
      wr(6'h2C, 16'h0000);
      rd(6'h24, rv);
      wr(6'h1C, 16'(VECS[i][6]) << ln);
      wr(6'h08, ~(16'(VECS[i][4]) << ln));
      wr(6'h2C, 16'(VECS[i][5]) << ln);
      @(negedge clk) pin_in = 16'(VECS[i][2]) << ln;
      settle();
      rd(6'h24, rv);
      @(negedge clk);
      func_clk_en = ~VECS[i][3];
      pin_in = 16'(VECS[i][1]) << ln;
      settle();
      chk({tag, " irq"}, {15'd0, irq}, {15'd0, VECS[i][0]});
      rd(6'h24, rv);
      chk({tag, " status"}, rv, 16'(VECS[i][0]) << ln);
      func_clk_en = 1'b1;
    end

    // Clean state for the directed tests
    wr(6'h08, 16'hFFFF);
    wr(6'h2C, 16'h0000);
    wr(6'h1C, 16'h0000);
    @(negedge clk) pin_in = 16'h0000;
    settle();
    rd(6'h24, rv);

    // R9 synchronizer latency
    @(negedge clk) pin_in = 16'h3C0F;
    @(posedge clk);
    rd(6'h00, rv); chk("R9 old value", rv, 16'h0000);
    rd(6'h00, rv); chk("R9 new value", rv, 16'h3C0F);
    @(negedge clk) pin_in = 16'h0000;
    settle();
    rd(6'h24, rv);

    // R2 output drive
    wr(6'h04, 16'hA5A5);
    wr(6'h08, 16'h00FF);
    chk("R2 pin_out", pin_out, 16'hA500);
    chk("R2 pin_oe", pin_oe, 16'hFF00);
    rd(6'h04, rv); chk("R2 out readback", rv, 16'hA5A5);
    wr(6'h08, 16'hFFFF);
    chk("R2 pin_out after dir", pin_out, 16'h0000);

    // R10 rdata holds across a write
    wr(6'h04, 16'h1111);
    chk("R10 rdata hold", reg_rdata, 16'hA5A5);

    // R5 masked bits kept on read
    wr(6'h1C, 16'h0008);
    @(negedge clk) pin_in = 16'h0008;
    settle();
    wr(6'h2C, 16'h0008);
    rd(6'h24, rv); chk("R5 masked read 1", rv, 16'h0008);
    rd(6'h24, rv); chk("R5 masked kept", rv, 16'h0008);
    chk("R5 irq kept", {15'd0, irq}, 16'h0001);
    wr(6'h2C, 16'h0000);
    rd(6'h24, rv); chk("R5 unmasked read", rv, 16'h0008);
    rd(6'h24, rv); chk("R5 cleared", rv, 16'h0000);
    wr(6'h1C, 16'h0000);
    @(negedge clk) pin_in = 16'h0000;
    settle();
    rd(6'h24, rv);

    // R6 event capture on pin 5
    wr(6'h18, 16'h000B);
    @(negedge clk) pin_in = 16'h1234;
    settle();
    rd(6'h34, rv); chk("R6 capture", rv, 16'h1234);
    @(negedge clk) pin_in = 16'h1235;
    settle();
    rd(6'h34, rv); chk("R6 other pin", rv, 16'h1234);
    @(negedge clk) pin_in = 16'h1215;
    settle();
    rd(6'h34, rv); chk("R6 falling capture", rv, 16'h1215);
    wr(6'h18, 16'h000A);
    @(negedge clk) pin_in = 16'h1235;
    settle();
    rd(6'h34, rv); chk("R6 disabled", rv, 16'h1215);

    // R7 field widths
    wr(6'h18, 16'hFFFF);
    rd(6'h18, rv); chk("R7 evt width", rv, 16'h001F);
    wr(6'h30, 16'hFFFF);
    rd(6'h30, rv); chk("R7 debounce width", rv, 16'h01FF);
    wr(6'h2C, 16'hBEEF);
    rd(6'h2C, rv); chk("R7 mask full", rv, 16'hBEEF);
    wr(6'h2C, 16'h0000);
    wr(6'h18, 16'h0000);

    // R8 read-only and unmapped offsets
    rd(6'h24, rv);
    wr(6'h00, 16'hFFFF);
    rd(6'h00, rv); chk("R8 input write ignored", rv, 16'h1235);
    wr(6'h24, 16'hFFFF);
    rd(6'h24, rv); chk("R8 status write ignored", rv, 16'h0000);
    wr(6'h34, 16'h0000);
    rd(6'h34, rv); chk("R8 latch write ignored", rv, 16'h1215);
    wr(6'h0C, 16'h5555);
    rd(6'h04, rv); chk("R8 unmapped write", rv, 16'h1111);
    rd(6'h0C, rv); chk("R8 unmapped read", rv, 16'h0000);
    rd(6'h3C, rv); chk("R8 unmapped read hi", rv, 16'h0000);

    report();
  end
endmodule